// File: doc/BRIEF.md
# Multichannel Edge Timestamp Unit

This block records when edges arrive on a small set of asynchronous input lines. All channels share one free-running counter, which advances at a rate set by a programmable divider. When a channel sees the edge kind chosen for it, the counter value from that cycle is stored in the channel's capture register. The channel's interrupt status bit is also set. Software turns successive timestamps into periods or pulse widths. A common method is to flip a channel between rising and falling selection after each event, which yields the high time and the low time in turn.

The unit is reached through a 32-bit, word-aligned register port with a single write strobe and a combinational read path. The register layout is as follows:
- Capture values sit at 0x10 + 4·n and edge selects at 0x30 + 4·n.
- The control word is at 0x50. Bit 10 is the run enable and bits 8:4 hold the divider value.
- The interrupt enable mask is at 0x54 and the sticky status is at 0x58. In both, channel n uses bit n+1.
- The write-one-to-clear acknowledge word is at 0x5C.

A single level interrupt output combines the status bits with the enable mask.

Top module: `capt_unit`

## Requirements
- R1: After reset every register reads zero: control, interrupt enable, status, each capture value and each edge select. The interrupt output is low.
- R2: Edge select code 0 captures nothing, 1 captures rising edges only, 2 captures falling edges only, and 3 captures both edges.
- R3: An input change applied before clock edge c is seen by the two-flop synchroniser and the edge detector during the cycle after edge c+1. The counter value of that cycle is stored into the channel's capture register at edge c+2.
- R4: While running with divider value p, the counter starts from zero at the enabling write and advances by one every p+1 cycles. With the enabling write at edge E, the value in the cycle after edge E+j is floor(j/(p+1)).
- R5: While control bit 10 is zero, edges are ignored, capture registers and status keep their values, and the counter is held at zero.
- R6: A capture on channel n sets bit n+1 of the status register at 0x58. The bit stays set until it is acknowledged.
- R7: The interrupt output is high exactly when some status bit is set whose matching bit n+1 in the enable register at 0x54 is also set.
- R8: A write to 0x5C clears the status bits written with one and leaves the bits written with zero.
- R9: When an acknowledge and a new capture hit the same status bit in the same cycle, the bit stays set.
- R10: A rewritten edge select reads back in bits 1:0 and applies from the next edge onward.
- R11: A capture on one channel leaves every other channel's capture register and status bit unchanged.
- R12: The control word reads back only bit 10 and bits 8:4. Unmapped or misaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NUM_CH | Asynchronous signals to be timestamped |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench computes each expected timestamp from its own cycle count relative to the enabling write, so a design with a different synchroniser depth or a divider that is off by one stores a value that differs by one or more. It forces an acknowledge into the very cycle a new capture sets the same bit; a design that lets the clear win loses the event, and status reads zero. It rewrites the edge selection between events and toggles inputs while the unit is stopped. A design that reuses a stale selection, keeps counting while disabled, or captures while disabled shows a wrong or unexpected timestamp. Acknowledges with partial masks and a masked interrupt check that status clearing and interrupt gating stay per bit.

// File: rtl/capt_pkg.sv
package capt_pkg;

  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_VALUE = 8'h10;
  localparam logic [7:0] OFS_SEL   = 8'h30;
  localparam logic [7:0] OFS_CTRL  = 8'h50;
  localparam logic [7:0] OFS_IEN   = 8'h54;
  localparam logic [7:0] OFS_STAT  = 8'h58;
  localparam logic [7:0] OFS_ACK   = 8'h5C;

  localparam int unsigned CTRL_RUN_BIT = 10;
  localparam int unsigned CTRL_PS_LSB  = 4;
  localparam int unsigned IRQ_LSB      = 1;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  function automatic logic edge_match(edge_sel_e sel, logic prev, logic cur);
    logic hit;
    case (sel)
      EDGE_RISE: hit = !prev && cur;
      EDGE_FALL: hit = prev && !cur;
      EDGE_ANY:  hit = prev != cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic [7:0] slot_addr(logic [7:0] base, int idx);
    return base + 8'(4 * idx);
  endfunction

endpackage

// File: rtl/capt_timebase.sv
module capt_timebase #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PS_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PS_W-1:0]  prescale,
  output logic [CNT_W-1:0] count
);

  logic [PS_W-1:0]  div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick  = run && (div_q == prescale);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      div_q <= div_q + PS_W'(1);
    end
  end

endmodule

// File: rtl/capt_channel.sv
module capt_channel
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  edge_sel_e        sel,
  input  logic             pin,
  input  logic [CNT_W-1:0] count,
  output logic             evt,
  output logic [CNT_W-1:0] value
);

  localparam int unsigned SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_MSB];
    end
  end

  assign evt = run && edge_match(sel, prev_q, sync_q[SYNC_MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value_q <= '0;
    else if (evt) value_q <= count;
  end

  assign value = value_q;

endmodule

// File: rtl/capt_irq.sv
module capt_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] ack,
  input  logic [NUM_CH-1:0] ien,
  output logic [NUM_CH-1:0] stat,
  output logic              irq
);

  logic [NUM_CH-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~ack) | evt;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & ien);

endmodule

// File: rtl/capt_unit.sv
module capt_unit
  import capt_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PS_W        = 5,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int unsigned IRQ_MSB = IRQ_LSB + NUM_CH - 1;

  logic              run_q;
  logic [PS_W-1:0]   ps_q;
  logic [NUM_CH-1:0] ien_q;
  edge_sel_e         sel_q [NUM_CH];

  logic [CNT_W-1:0]  tb_count;
  logic [NUM_CH-1:0] cap_evt;
  logic [CNT_W-1:0]  cap_val [NUM_CH];
  logic [NUM_CH*CNT_W-1:0] cap_flat;
  logic [NUM_CH-1:0] int_stat;
  logic [NUM_CH-1:0] ack_mask;
  logic [NUM_CH-1:0] wr_sel;

  logic wr_ctrl, wr_ien, wr_ack;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
  assign wr_ack   = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
  assign ack_mask = wr_ack ? bus_wdata[IRQ_MSB:IRQ_LSB] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ps_q  <= '0;
      ien_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[CTRL_RUN_BIT];
        ps_q  <= bus_wdata[CTRL_PS_LSB +: PS_W];
      end
      if (wr_ien) ien_q <= bus_wdata[IRQ_MSB:IRQ_LSB];
    end
  end

  capt_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) i_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .prescale (ps_q),
    .count    (tb_count)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign wr_sel[n] = bus_wr && (bus_addr == ADDR_W'(slot_addr(OFS_SEL, n)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[n] <= EDGE_OFF;
      else if (wr_sel[n]) sel_q[n] <= edge_sel_e'(bus_wdata[1:0]);
    end

    capt_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_channel (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .sel   (sel_q[n]),
      .pin   (cap_in[n]),
      .count (tb_count),
      .evt   (cap_evt[n]),
      .value (cap_val[n])
    );

    assign cap_flat[n*CNT_W +: CNT_W] = cap_val[n];
  end

  capt_irq #(.NUM_CH(NUM_CH)) i_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (cap_evt),
    .ack   (ack_mask),
    .ien   (ien_q),
    .stat  (int_stat),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[CTRL_RUN_BIT]        = run_q;
      bus_rdata[CTRL_PS_LSB +: PS_W] = ps_q;
    end
    if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata[IRQ_MSB:IRQ_LSB] = ien_q;
    if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata[IRQ_MSB:IRQ_LSB] = int_stat;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(slot_addr(OFS_VALUE, n))) bus_rdata = BUS_W'(cap_val[n]);
      if (bus_addr == ADDR_W'(slot_addr(OFS_SEL, n)))   bus_rdata[1:0] = sel_q[n];
    end
  end

endmodule

// File: rtl/capt_checker.sv
module capt_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run,
  input logic [NUM_CH-1:0]       evt,
  input logic [NUM_CH-1:0]       stat,
  input logic [NUM_CH-1:0]       ien,
  input logic [NUM_CH-1:0]       ack_mask,
  input logic                    irq,
  input logic [CNT_W-1:0]        count,
  input logic [NUM_CH*CNT_W-1:0] cap_flat
);

  // R6
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask == '0) |=> ((stat & $past(stat)) == $past(stat)));

  // R9
  evt_over_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ack_mask) != '0) |=> ((stat & $past(evt & ack_mask)) == $past(evt & ack_mask)));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ien) == '0) |-> !irq);

  // R5
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  // R5
  idle_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (evt == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (!run || count == $past(count) || count == $past(count) + CNT_W'(1)));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_val
    // R3
    cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[n] |=> (cap_flat[n*CNT_W +: CNT_W] == $past(count)));
  end

endmodule

bind capt_unit capt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .evt      (cap_evt),
  .stat     (int_stat),
  .ien      (ien_q),
  .ack_mask (ack_mask),
  .irq      (irq),
  .count    (tb_count),
  .cap_flat (cap_flat)
);

// File: tb/test_capt_unit.sv
module test_capt_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cap_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int en_cyc = 0;
  int ps_val = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  capt_unit i_capt_unit (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 at = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr0(input logic [7:0] a, input logic [31:0] d);
    int unused_at;
    wr(a, d, unused_at);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic start(input int p);
    wr(8'h50, 32'h400 | (p << 4), en_cyc);
    ps_val = p;
  endtask

  // drive a pin, return the posedge index c that first samples it; waits past c+2
  task automatic pin(input int ch, input logic v, output int c);
    @(negedge clk);
    cap_in[ch] = v;
    @(posedge clk); #1 c = cyc;
    @(posedge clk);
    @(posedge clk);
  endtask

  function automatic logic [31:0] stamp(input int c);
    return 32'((c + 1 - en_cyc) / (ps_val + 1));
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h50, d); chk("R1 ctrl", d, 0);
    rd(8'h54, d); chk("R1 ien", d, 0);
    rd(8'h58, d); chk("R1 stat", d, 0);
    rd(8'h10, d); chk("R1 val0", d, 0);
    rd(8'h3C, d); chk("R1 sel3", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr0(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, d); chk("R12 ctrl readback", d, 32'h5F0);
    wr0(8'h50, 32'h0);
    rd(8'h60, d); chk("R12 unmapped", d, 0);
    rd(8'h12, d); chk("R12 misaligned", d, 0);
    wr0(8'h30, 32'hFF);
    rd(8'h30, d); chk("R10 sel readback", d, 3);
    wr0(8'h30, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d, v;
    int c;
    wr0(8'h30, 32'd1);
    start(0);
    repeat (5) @(posedge clk);
    pin(0, 1'b1, c);
    v = stamp(c);
    rd(8'h10, d); chk("R3 rise stamp", d, v);
    rd(8'h58, d); chk("R6 stat ch0", d, 32'h2);
    rd(8'h14, d); chk("R11 val1 untouched", d, 0);
    chk("R7 irq masked", 32'(irq), 0);
    pin(0, 1'b0, c);
    rd(8'h10, d); chk("R2 rise ignores fall", d, v);
    wr0(8'h5C, 32'h1FF);
  endtask

  task automatic t_sel_change();
    logic [31:0] d, v;
    int c;
    rd(8'h10, v);
    wr0(8'h30, 32'd2);
    pin(0, 1'b1, c);
    rd(8'h10, d); chk("R2 fall ignores rise", d, v);
    rd(8'h58, d); chk("R2 no stat on rise", d, 0);
    pin(0, 1'b0, c);
    rd(8'h10, d); chk("R10 new sel fall stamp", d, stamp(c));
    wr0(8'h5C, 32'h1FF);
    wr0(8'h30, 32'd3);
    pin(0, 1'b1, c);
    rd(8'h10, d); chk("R2 both rise", d, stamp(c));
    pin(0, 1'b0, c);
    rd(8'h10, d); chk("R2 both fall", d, stamp(c));
    wr0(8'h5C, 32'h1FF);
    wr0(8'h30, 32'd0);
    rd(8'h10, v);
    pin(0, 1'b1, c);
    rd(8'h58, d); chk("R2 off no stat", d, 0);
    rd(8'h10, d); chk("R2 off no capture", d, v);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    int c;
    wr0(8'h30, 32'd3);
    wr0(8'h34, 32'd3);
    pin(0, 1'b0, c);
    pin(1, 1'b1, c);
    rd(8'h58, d); chk("R6 two stat bits", d, 32'h6);
    wr0(8'h5C, 32'h2);
    rd(8'h58, d); chk("R8 partial ack", d, 32'h4);
    wr0(8'h5C, 32'h1FF);
    rd(8'h58, d); chk("R8 full ack", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    int c;
    wr0(8'h54, 32'h2);
    rd(8'h54, d); chk("R7 ien readback", d, 32'h2);
    pin(1, 1'b0, c);
    @(negedge clk); chk("R7 irq off for masked ch1", 32'(irq), 0);
    pin(0, 1'b1, c);
    @(negedge clk); chk("R7 irq on for ch0", 32'(irq), 1);
    wr0(8'h5C, 32'h2);
    chk("R7 irq off after ack", 32'(irq), 0);
    wr0(8'h54, 32'h0);
    wr0(8'h5C, 32'h1FF);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    int c;
    wr0(8'h50, 32'h0);
    wr0(8'h38, 32'd1);
    start(3);
    repeat (9) @(posedge clk);
    pin(2, 1'b1, c);
    rd(8'h18, d); chk("R4 divide by four", d, stamp(c));
    wr0(8'h5C, 32'h1FF);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int c;
    wr0(8'h50, 32'h0);
    wr0(8'h3C, 32'd3);
    repeat (20) @(posedge clk);
    pin(3, 1'b1, c);
    rd(8'h58, d); chk("R5 no stat while stopped", d, 0);
    rd(8'h1C, d); chk("R5 no capture while stopped", d, 0);
    start(0);
    pin(3, 1'b0, c);
    rd(8'h1C, d); chk("R5 counter restarts from zero", d, stamp(c));
    wr0(8'h5C, 32'h1FF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    int c;
    wr0(8'h30, 32'd3);
    pin(0, 1'b0, c);
    rd(8'h58, d); chk("R6 stat before collision", d, 32'h2);
    @(negedge clk);
    cap_in[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h5C; bus_wdata = 32'h2;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h58, d); chk("R9 event beats ack", d, 32'h2);
    wr0(8'h5C, 32'h2);
    rd(8'h58, d); chk("R8 ack clears afterwards", d, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_rise();
    t_sel_change();
    t_ack();
    t_irq();
    t_prescale();
    t_disable();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule